// File: doc/BRIEF.md
# Predicated Vector Element Register Writer

This block accepts one vector write request at a time and turns it into a run of writes on a small register file of 64-bit registers. The storage sits inside the block. A request carries a starting register number, an element size code, an element count and a densely packed result vector. It also carries one predicate bit per element. The block treats the elements as one continuous byte stream. That stream starts in the low byte of the starting register and flows upward into the next-numbered registers. An element may end partway through a register, and the next register then takes the elements that follow.

Every register lane has its own byte write enable. A predicate bit that is clear removes the enables of the bytes its element covers. Masked elements and the unused upper part of the last register therefore keep their old contents without any read-modify-write cycle. The sequencer steps through the registers a request touches, one per clock, from the lowest offset to the highest. A register that would get no enabled byte is stepped over without a write. A one-cycle completion pulse follows the last step. A read port lets the surrounding logic inspect any register.

Top module: `pvec_writer`

## Requirements
- R1: After reset every register reads zero, `req_ready` is 1, and `done` and `wr_valid` are 0.
- R2: Element i of a request occupies bits [i*W +: W] of `req_data`, where the width code `req_ew` gives W: 0 for 8, 1 for 16, 2 for 32 and 3 for 64 bits. Stream byte j goes to register (base + j/8) in lane j%8, and lane 0 is bits [7:0].
- R3: A clear predicate bit (bit i of `req_pred` for element i) leaves every byte of element i unchanged. A set bit writes all of them.
- R4: At 8-bit width each predicate bit gates exactly one byte lane.
- R5: With 16-bit elements and a count of 5, elements 0 to 3 fill the starting register. Element 4 lands in bits [15:0] of the next register, and bits [63:16] of that register keep their old value.
- R6: Register numbers wrap modulo 32, so the register after 31 is 0.
- R7: One step is taken per clock, with register offset 0, 1, 2 and so on. During the step at offset k, `wr_idx` is (base+k) mod 32. `wr_valid` is 1 exactly when at least one byte of that register is enabled. A register with no enabled byte is not written.
- R8: A request with count n>0 at width B bytes takes ceil(n*B/8) steps. The steps start in the cycle after acceptance, `done` is high for exactly one cycle directly after the last step, and `req_ready` is low during the steps.
- R9: A request with count 0 writes nothing and raises `done` in the cycle after acceptance.
- R10: A request presented while `req_ready` is low is ignored and changes no register.
- R11: A count above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | Block is idle and can take a request |
| req_base | input | 5 | Starting register number |
| req_ew | input | 2 | Element width code |
| req_vl | input | 5 | Element count (0 to 16, larger values clamp) |
| req_data | input | 1024 | Densely packed result elements |
| req_pred | input | 16 | Per-element write predicate |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | A register write happens at the next edge |
| wr_idx | output | 5 | Register being written |
| wr_be | output | 8 | Byte enables of the current write |
| rd_addr | input | 5 | Read port register number |
| rd_data | output | 64 | Read port data, combinational |

## Verification
After a request is accepted at a clock edge, the step for offset k is visible on `wr_valid`, `wr_idx` and `wr_be` in the k-th cycle after that edge, counting from zero. Its bytes land in storage at the edge that closes that cycle. `done` is due in cycle ceil(n*B/8), or in cycle 0 for an empty request, and must drop in the following cycle. The bench samples on the falling edge and counts these cycles from the accepting edge. It compares each step and the `done` position with values it derives from the request alone. Only after `done` does it read every register through the combinational read port and compare it against its own byte model.

// File: rtl/pvw_pkg.sv
package pvw_pkg;
    localparam int LANES    = 8;
    localparam int REG_BITS = LANES * 8;

    typedef enum logic [1:0] {
        EW_B8  = 2'b00,
        EW_B16 = 2'b01,
        EW_B32 = 2'b10,
        EW_B64 = 2'b11
    } ew_e;
endpackage

// File: rtl/pvw_lane_mask.sv
module pvw_lane_mask
    import pvw_pkg::*;
#(
    parameter int MAX_VL = 16,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic [VL_W-1:0]   off,
    input  logic [1:0]        ew,
    input  logic [VL_W-1:0]   vl,
    input  logic [MAX_VL-1:0] pred,
    output logic [LANES-1:0]  be
);
    // stream byte j belongs to element j >> ew; enable if inside count and predicated
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            int sb;
            int el;
            sb = int'(off) * LANES + l;
            el = sb >> ew;
            be[l] = 1'b0;
            if (el < int'(vl) && el < MAX_VL) begin
                be[l] = pred[el];
            end
        end
    end
endmodule

// File: rtl/pvw_regfile.sv
module pvw_regfile
    import pvw_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int RIDX_W  = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [RIDX_W-1:0]   waddr,
    input  logic [LANES-1:0]    wbe,
    input  logic [REG_BITS-1:0] wdata,
    input  logic [RIDX_W-1:0]   raddr,
    output logic [REG_BITS-1:0] rdata
);
    logic [7:0] mem_q [NUM_REGS][LANES];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar b = 0; b < LANES; b++) begin : g_byte
            logic hit;
            assign hit = we && (int'(waddr) == r) && wbe[b];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem_q[r][b] <= '0;
                end else if (hit) begin
                    mem_q[r][b] <= wdata[b*8 +: 8];
                end
            end

            // R3: a byte lane whose enable is low keeps its contents
            assert_byte_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && int'(waddr) == r && wbe[b]) |=> $stable(mem_q[r][b]));
        end
    end

    always_comb begin
        for (int b = 0; b < LANES; b++) begin
            rdata[b*8 +: 8] = mem_q[raddr][b];
        end
    end
endmodule

// File: rtl/pvw_seq.sv
module pvw_seq
    import pvw_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int MAX_VL   = 16,
    localparam int RIDX_W  = $clog2(NUM_REGS),
    localparam int VL_W    = $clog2(MAX_VL + 1),
    localparam int DATA_W  = MAX_VL * REG_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [RIDX_W-1:0]   req_base,
    input  logic [1:0]          req_ew,
    input  logic [VL_W-1:0]     req_vl,
    input  logic [DATA_W-1:0]   req_data,
    input  logic [MAX_VL-1:0]   req_pred,
    output logic                req_ready,
    output logic                busy,
    output logic                done,
    output logic [VL_W-1:0]     cur_off,
    output logic [RIDX_W-1:0]   cur_base,
    output logic [1:0]          cur_ew,
    output logic [VL_W-1:0]     cur_vl,
    output logic [MAX_VL-1:0]   cur_pred,
    output logic [REG_BITS-1:0] cur_word
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic [VL_W-1:0]   off;
        logic [VL_W-1:0]   last;
        logic [RIDX_W-1:0] base;
        logic [1:0]        ew;
        logic [VL_W-1:0]   vl;
        logic [MAX_VL-1:0] pred;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t st_d, st_q;

    logic [VL_W-1:0] vl_clamp;
    logic [VL_W+2:0] nbytes;
    logic [VL_W+2:0] nregs;

    always_comb begin
        vl_clamp = (int'(req_vl) > MAX_VL) ? VL_W'(MAX_VL) : req_vl;
        nbytes   = {3'b000, vl_clamp} << req_ew;
        nregs    = (nbytes + (VL_W+3)'(7)) >> 3;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.off == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.off = st_q.off + VL_W'(1);
            end
        end else if (req_valid) begin
            st_d.base = req_base;
            st_d.ew   = req_ew;
            st_d.vl   = vl_clamp;
            st_d.pred = req_pred;
            st_d.data = req_data;
            st_d.off  = '0;
            st_d.last = nregs[VL_W-1:0] - VL_W'(1);
            if (vl_clamp == '0) begin
                st_d.done = 1'b1;
            end else begin
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.busy;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign cur_off   = st_q.off;
    assign cur_base  = st_q.base;
    assign cur_ew    = st_q.ew;
    assign cur_vl    = st_q.vl;
    assign cur_pred  = st_q.pred;
    assign cur_word  = st_q.data[int'(st_q.off) * REG_BITS +: REG_BITS];

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: offsets advance by one per clock while stepping
    assert_step_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_off != st_q.last) |=> (busy && cur_off == $past(cur_off) + VL_W'(1)));
    // R9: an empty request finishes in the next cycle without stepping
    assert_empty_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_vl == '0) |=> (done && !busy));
    // R10: a request offered while busy does not disturb the latched one
    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cur_base) && $stable(cur_pred) && $stable(cur_ew)));
endmodule

// File: rtl/pvec_writer.sv
module pvec_writer
    import pvw_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int MAX_VL   = 16,
    localparam int RIDX_W  = $clog2(NUM_REGS),
    localparam int VL_W    = $clog2(MAX_VL + 1),
    localparam int DATA_W  = MAX_VL * REG_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [RIDX_W-1:0]   req_base,
    input  logic [1:0]          req_ew,
    input  logic [VL_W-1:0]     req_vl,
    input  logic [DATA_W-1:0]   req_data,
    input  logic [MAX_VL-1:0]   req_pred,
    output logic                done,
    output logic                wr_valid,
    output logic [RIDX_W-1:0]   wr_idx,
    output logic [LANES-1:0]    wr_be,
    input  logic [RIDX_W-1:0]   rd_addr,
    output logic [REG_BITS-1:0] rd_data
);
    logic                busy;
    logic [VL_W-1:0]     cur_off;
    logic [RIDX_W-1:0]   cur_base;
    logic [1:0]          cur_ew;
    logic [VL_W-1:0]     cur_vl;
    logic [MAX_VL-1:0]   cur_pred;
    logic [REG_BITS-1:0] cur_word;
    logic [LANES-1:0]    lane_be;

    pvw_seq #(.NUM_REGS(NUM_REGS), .MAX_VL(MAX_VL)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_base(req_base), .req_ew(req_ew),
        .req_vl(req_vl), .req_data(req_data), .req_pred(req_pred),
        .req_ready(req_ready), .busy(busy), .done(done),
        .cur_off(cur_off), .cur_base(cur_base), .cur_ew(cur_ew),
        .cur_vl(cur_vl), .cur_pred(cur_pred), .cur_word(cur_word)
    );

    pvw_lane_mask #(.MAX_VL(MAX_VL)) u_mask (
        .off(cur_off), .ew(cur_ew), .vl(cur_vl), .pred(cur_pred), .be(lane_be)
    );

    assign wr_be    = busy ? lane_be : '0;
    assign wr_valid = busy && (|lane_be);
    assign wr_idx   = RIDX_W'((int'(cur_base) + int'(cur_off)) % NUM_REGS);

    pvw_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(wr_valid), .waddr(wr_idx), .wbe(wr_be), .wdata(cur_word),
        .raddr(rd_addr), .rdata(rd_data)
    );

    // enables inside one element must all agree
    logic be_grouped;
    always_comb begin
        int eb;
        eb = 1 << cur_ew;
        be_grouped = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            if (wr_be[l] != wr_be[(l / eb) * eb]) be_grouped = 1'b0;
        end
    end

    // R3: one predicate bit governs every lane of its element
    assert_elem_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> be_grouped);
    // R7: writes happen only while stepping, never while idle
    assert_write_in_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !req_ready);
    // R6: successive steps target successive register numbers modulo the file size
    assert_idx_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && cur_off != '0) |->
        (int'(wr_idx) == (int'($past(wr_idx)) + 1) % NUM_REGS));
endmodule

// File: tb/pvec_writer_test.sv
`timescale 1ns/1ps
module pvec_writer_test;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [4:0]    req_base = '0;
    logic [1:0]    req_ew = '0;
    logic [4:0]    req_vl = '0;
    logic [1023:0] req_data = '0;
    logic [15:0]   req_pred = '0;
    logic          done;
    logic          wr_valid;
    logic [4:0]    wr_idx;
    logic [7:0]    wr_be;
    logic [4:0]    rd_addr = '0;
    logic [63:0]   rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [63:0] model [32];

    always #2 clk = ~clk;

    pvec_writer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_ew(req_ew), .req_vl(req_vl), .req_data(req_data),
        .req_pred(req_pred), .done(done), .wr_valid(wr_valid), .wr_idx(wr_idx),
        .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    task automatic check_regs(input string req);
        int first;
        logic [63:0] g, e;
        first = -1;
        for (int r = 0; r < 32; r++) begin
            rd_addr = 5'(r);
            #0.5;
            if (rd_data !== model[r] && first < 0) begin
                first = r; g = rd_data; e = model[r];
            end
        end
        if (first < 0) chk(1, req, "regfile", 0, 0);
        else chk(0, req, $sformatf("reg%0d", first), g, e);
    endtask

    task automatic do_req(input int base, input int ew, input int vl,
                          input logic [1023:0] data, input logic [15:0] pred,
                          input bit junk, input string req);
        int vlc, eb, nb, nr, c, seqerr;
        bit any [16];
        bit seen;
        vlc = (vl > 16) ? 16 : vl;
        eb = 1 << ew;
        nb = vlc * eb;
        nr = (nb + 7) / 8;
        for (int k = 0; k < 16; k++) any[k] = 0;
        for (int j = 0; j < nb; j++) begin
            if (pred[j >> ew]) begin
                any[j / 8] = 1;
                model[(base + j / 8) % 32][(j % 8) * 8 +: 8] = data[j * 8 +: 8];
            end
        end
        @(negedge clk);
        req_base = 5'(base); req_ew = 2'(ew); req_vl = 5'(vl);
        req_data = data; req_pred = pred; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (junk && nr >= 2) begin
            req_base = req_base + 5'd3; req_data = ~data; req_pred = 16'hffff;
        end else begin
            req_valid = 1'b0;
        end
        seqerr = 0;
        seen = 0;
        for (c = 0; c < nr + 20; c++) begin
            if (c < nr) begin
                if (wr_valid !== any[c]) seqerr++;
                if (wr_valid && wr_idx !== 5'((base + c) % 32)) seqerr++;
                if (done !== 1'b0 || req_ready !== 1'b0) seqerr++;
                if (c == nr - 1) req_valid = 1'b0;
            end else if (done === 1'b1) begin
                seen = 1;
                break;
            end
            @(posedge clk);
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(seqerr == 0, "R7", $sformatf("%s step errors", req), 64'(seqerr), 0);
        chk(seen && c == nr, (vlc == 0) ? "R9" : "R8", $sformatf("%s done cycle", req),
            64'(c), 64'(nr));
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0 && req_ready === 1'b1, "R8", "done pulse drop",
            {62'd0, done, req_ready}, 64'd1);
        check_regs(req);
    endtask

    function automatic logic [1023:0] rnd_vec();
        logic [1023:0] v;
        for (int w = 0; w < 32; w++) v[w * 32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1023:0] d;
        void'($urandom(32'd1234));
        for (int r = 0; r < 32; r++) model[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(req_ready === 1'b1 && done === 1'b0 && wr_valid === 1'b0, "R1", "reset outputs",
            {61'd0, req_ready, done, wr_valid}, 64'h4);
        check_regs("R1");

        // R2: 32-bit elements, all predicated
        d = rnd_vec();
        do_req(4, 2, 6, d, 16'hffff, 0, "R2");
        // R5: preload with ones, then 16-bit count 5
        do_req(10, 3, 2, {1024{1'b1}}, 16'hffff, 0, "R5");
        d = rnd_vec();
        do_req(10, 1, 5, d, 16'h001f, 0, "R5");
        rd_addr = 5'd11;
        #0.5;
        chk(rd_data[63:16] === 48'hffff_ffff_ffff && rd_data[15:0] === d[79:64], "R5",
            "spill register", rd_data, {48'hffff_ffff_ffff, d[79:64]});
        // R4: 8-bit alternating predicate
        d = rnd_vec();
        do_req(20, 0, 16, d, 16'h5a5a, 0, "R4");
        // R6: wrap past register 31
        d = rnd_vec();
        do_req(31, 0, 16, d, 16'hffff, 0, "R6");
        // R7: all predicates clear, registers stepped without writes
        d = rnd_vec();
        do_req(2, 3, 4, d, 16'h0000, 0, "R7");
        // R9: empty request
        do_req(7, 2, 0, rnd_vec(), 16'hffff, 0, "R9");
        // R10: junk request held while busy
        d = rnd_vec();
        do_req(14, 3, 5, d, 16'h0015, 1, "R10");
        // R11: count above the limit clamps
        d = rnd_vec();
        do_req(16, 3, 20, d, 16'hffff, 0, "R11");
        // R3: random mix
        for (int t = 0; t < 150; t++) begin
            int b, e, v;
            logic [15:0] p;
            b = int'($urandom % 32);
            e = int'($urandom % 4);
            v = int'($urandom % 19);
            p = (t % 5 == 0) ? 16'hffff : 16'($urandom);
            do_req(b, e, v, rnd_vec(), p, (t % 7 == 0), "R3");
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule